// File: doc/BRIEF.md
# Dot Clock PLL Parameter Search

This block turns a requested dot clock frequency, given in hertz, into the settings of a clock synthesizer that runs from a fixed 14.31818 MHz reference. It picks a feedback count M, a reference divide N, a power-of-two post-divide and a loop-divide select. The outputs are register-ready: M-2, N-2 and a packed divisor byte. A host pulses `start` with a 32-bit target. The engine scales the target, divides it by the reference once, then sweeps N at one value per clock. At the end it raises `done` for one cycle and holds the results.

A target outside the legal frequency window is refused on the cycle after `start`. In that case no search runs and a range-error flag is set. When the feedback count would be too large for a direct setting, a four-times loop divide is used. This lets the search consider M values up to four times the normal ceiling. Only the precision that the 8-bit field can hold counts toward the error of such a candidate.

Top module: `dclk_pll_search`

## Requirements
- R1: While reset is held and until the first accepted `start`, all outputs are zero.
- R2: A `start` with a target above 220000000 or below 3125000 gives, one clock after the start edge, a one-cycle `done` together with `range_err`=1, `no_sol`=0 and all three codes zero. `busy` stays low.
- R3: The limits themselves, 3125000 and 220000000, are accepted and searched.
- R4: The working target is doubled until it is at least 100000000. The number of doublings is placed in bits 7:4 of `div_code`.
- R5: For every N from 3 to 257 the candidate is M = N*q + floor(N*r/14318180), where q and r are the quotient and remainder of the scaled target over the reference. The candidate's error is |target*N - 14318180*M|. The smallest error wins, and on a tie the smaller N wins. `n_code` = N-2.
- R6: A candidate with M from 258 to 1028 is scored with the two low bits of M cleared. A candidate with M outside 3..1028 is skipped.
- R7: If the winning M is above 257, `m_code` = (M>>2)-2 and bit 2 of `div_code` is 0. Otherwise `m_code` = M-2 and bit 2 is 1. Bits 3, 1 and 0 of `div_code` are always 0.
- R8: For an accepted start, `done` rises exactly k+q+261 clocks after the start edge, where k is the doubling count, and lasts one cycle. `busy` is high from the start edge up to the `done` edge.
- R9: A `start` that arrives while `busy` is high is ignored.
- R10: Results hold between `done` and the next accepted `start`. An accepted start clears the codes and flags to zero.
- R11: If no candidate qualifies, `done` comes with `no_sol`=1 and zero codes. For any accepted target `no_sol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search with `target_hz` |
| target_hz | input | 32 | Requested dot clock in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| range_err | output | 1 | Target was outside the legal window |
| no_sol | output | 1 | Sweep found no qualifying candidate |
| m_code | output | 8 | Feedback count minus two |
| n_code | output | 8 | Reference divide minus two |
| div_code | output | 8 | Post-divide exponent [7:4], loop-divide-one select [2] |

## Verification
Each internal stage has its own visible symptom.
- A wrong doubling count or a wrong quotient from the division stage shows twice. The upper nibble of `div_code` is wrong, and `done` rises on the wrong cycle, because both counts add to the latency.
- A drifting remainder accumulator in the sweep gives a wrong `m_code` or `n_code`, and this is visible only on the `done` cycle.
- A mis-scored extended candidate shows the same way. It can also flip bit 2 of the divisor byte.

The bench compares every output on every clock against an independent model. Any of these faults is therefore reported on the first cycle where a port differs.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PREP,
      ST_SWEEP,
      ST_FIN
   } top_st_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SCALE,
      PH_DIV,
      PH_HOLD
   } pre_ph_e;

   localparam int unsigned CODE_W = 8;
   localparam int unsigned EXP_W  = 4;

   function automatic logic [63:0] abs_gap(input logic [63:0] a, input logic [63:0] b);
      return (a >= b) ? (a - b) : (b - a);
   endfunction

endpackage

// File: rtl/dclk_prescale.sv
module dclk_prescale
   import dclk_pkg::*;
#(
   parameter int unsigned TW       = 32,
   parameter int unsigned RW       = 5,
   parameter int unsigned FLOOR_HZ = 100000000,
   parameter int unsigned REF_HZ   = 14318180
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TW-1:0]    target,
   output logic             fin,
   output logic [TW-1:0]    ft,
   output logic [EXP_W-1:0] expo,
   output logic [RW-1:0]    ratio,
   output logic [TW-1:0]    rem
);

   pre_ph_e ph;

   assign fin = (ph == PH_DIV) && (rem < TW'(REF_HZ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         ft    <= '0;
         expo  <= '0;
         ratio <= '0;
         rem   <= '0;
      end else if (load) begin
         ph    <= PH_SCALE;
         ft    <= target;
         expo  <= '0;
         ratio <= '0;
         rem   <= '0;
      end else begin
         case (ph)
            PH_SCALE: begin
               if (ft < TW'(FLOOR_HZ)) begin
                  ft   <= ft << 1;
                  expo <= expo + EXP_W'(1);
               end else begin
                  rem   <= ft;
                  ratio <= '0;
                  ph    <= PH_DIV;
               end
            end
            PH_DIV: begin
               if (rem >= TW'(REF_HZ)) begin
                  rem   <= rem - TW'(REF_HZ);
                  ratio <= ratio + RW'(1);
               end else begin
                  ph <= PH_HOLD;
               end
            end
            default: ph <= ph;
         endcase
      end
   end

   a_r4_scaled_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DIV) |-> (ft >= TW'(FLOOR_HZ)));

   a_r5_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DIV && !load && rem >= TW'(REF_HZ)) |=> (rem < $past(rem)));

endmodule

// File: rtl/dclk_mstep.sv
module dclk_mstep #(
   parameter int unsigned TW     = 32,
   parameter int unsigned NW     = 9,
   parameter int unsigned MW     = 13,
   parameter int unsigned RW     = 5,
   parameter int unsigned REF_HZ = 14318180
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [RW-1:0] ratio,
   input  logic [TW-1:0] rem,
   output logic [NW-1:0] n,
   output logic [MW-1:0] m
);

   logic [TW-1:0] acc;
   logic [TW:0]   sum;
   logic          wrap;

   assign sum  = {1'b0, acc} + {1'b0, rem};
   assign wrap = (sum >= (TW+1)'(REF_HZ));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n   <= '0;
         m   <= '0;
         acc <= '0;
      end else if (clear) begin
         n   <= '0;
         m   <= '0;
         acc <= '0;
      end else if (step) begin
         n <= n + NW'(1);
         if (wrap) begin
            acc <= TW'(sum - (TW+1)'(REF_HZ));
            m   <= m + MW'(ratio) + MW'(1);
         end else begin
            acc <= sum[TW-1:0];
            m   <= m + MW'(ratio);
         end
      end
   end

   a_r5_acc_below_ref: assert property (@(posedge clk) disable iff (!rst_n)
      acc < TW'(REF_HZ));

   a_r5_n_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear) |=> (n == $past(n) + NW'(1)));

endmodule

// File: rtl/dclk_score.sv
module dclk_score
   import dclk_pkg::*;
#(
   parameter int unsigned TW      = 32,
   parameter int unsigned NW      = 9,
   parameter int unsigned MW      = 13,
   parameter int unsigned REF_HZ  = 14318180,
   parameter int unsigned M_MIN   = 3,
   parameter int unsigned M_MAX   = 257,
   parameter int unsigned LOOP_SH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          eval,
   input  logic [TW-1:0] ft,
   input  logic [NW-1:0] n,
   input  logic [MW-1:0] m,
   output logic          best_ok,
   output logic [NW-1:0] best_n,
   output logic [MW-1:0] best_m
);

   localparam int unsigned M_EXT = M_MAX << LOOP_SH;

   logic [MW-1:0] m_eff;
   logic [63:0]   lhs, rhs, err, best_err;
   logic          in_rng, better;

   generate
      if (LOOP_SH > 0) begin : g_coarse
         localparam logic [MW-1:0] LOW_MASK = MW'((1 << LOOP_SH) - 1);
         assign m_eff = (m > MW'(M_MAX)) ? (m & ~LOW_MASK) : m;
      end else begin : g_plain
         assign m_eff = m;
      end
   endgenerate

   assign in_rng = (m >= MW'(M_MIN)) && (m <= MW'(M_EXT));
   assign lhs    = 64'(ft) * 64'(n);
   assign rhs    = 64'(REF_HZ) * 64'(m_eff);
   assign err    = abs_gap(lhs, rhs);
   assign better = eval && in_rng && (!best_ok || err < best_err);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_ok  <= 1'b0;
         best_n   <= '0;
         best_m   <= '0;
         best_err <= '0;
      end else if (clear) begin
         best_ok  <= 1'b0;
         best_n   <= '0;
         best_m   <= '0;
         best_err <= '0;
      end else if (better) begin
         best_ok  <= 1'b1;
         best_n   <= n;
         best_m   <= m;
         best_err <= err;
      end
   end

   a_r6_best_m_legal: assert property (@(posedge clk) disable iff (!rst_n)
      best_ok |-> (best_m >= MW'(M_MIN) && best_m <= MW'(M_EXT)));

   a_r5_error_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (best_ok && !clear) |=> (best_err <= $past(best_err)));

endmodule

// File: rtl/dclk_pll_search.sv
module dclk_pll_search
   import dclk_pkg::*;
#(
   parameter int unsigned TW       = 32,
   parameter int unsigned REF_HZ   = 14318180,
   parameter int unsigned FMIN_HZ  = 3125000,
   parameter int unsigned FMAX_HZ  = 220000000,
   parameter int unsigned FLOOR_HZ = 100000000,
   parameter int unsigned N_MIN    = 3,
   parameter int unsigned N_MAX    = 257,
   parameter int unsigned M_MIN    = 3,
   parameter int unsigned M_MAX    = 257,
   parameter int unsigned LOOP_SH  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] target_hz,
   output logic          busy,
   output logic          done,
   output logic          range_err,
   output logic          no_sol,
   output logic [7:0]    m_code,
   output logic [7:0]    n_code,
   output logic [7:0]    div_code
);

   localparam int unsigned FT_MAX    = (FMAX_HZ > 2*FLOOR_HZ) ? FMAX_HZ : 2*FLOOR_HZ;
   localparam int unsigned RATIO_MAX = FT_MAX / REF_HZ;
   localparam int unsigned RW        = $clog2(RATIO_MAX + 2);
   localparam int unsigned NW        = $clog2(N_MAX + 1);
   localparam int unsigned MW        = $clog2(N_MAX * (RATIO_MAX + 1) + 1);

   generate
      if (N_MIN < 2 || M_MIN < 2 || N_MAX > 257 || M_MAX > 257 ||
          REF_HZ >= FLOOR_HZ || FMIN_HZ == 0 || FMIN_HZ > FMAX_HZ) begin : g_bad_params
         $error("dclk_pll_search: illegal parameter set");
      end
   endgenerate

   top_st_e          st;
   logic             accept, reject, pre_fin;
   logic [TW-1:0]    ft, rem;
   logic [EXP_W-1:0] expo;
   logic [RW-1:0]    ratio;
   logic [NW-1:0]    n, best_n;
   logic [MW-1:0]    m, best_m, m_fin;
   logic             best_ok, step, eval, last, wide_m;

   assign reject = (target_hz > TW'(FMAX_HZ)) || (target_hz < TW'(FMIN_HZ));
   assign accept = (st == ST_IDLE) && start && !reject;
   assign step   = (st == ST_SWEEP);
   assign eval   = step && (n >= NW'(N_MIN));
   assign last   = step && (n == NW'(N_MAX));
   assign busy   = (st != ST_IDLE);
   assign wide_m = (best_m > MW'(M_MAX));
   assign m_fin  = wide_m ? (best_m >> LOOP_SH) : best_m;

   dclk_prescale #(.TW(TW), .RW(RW), .FLOOR_HZ(FLOOR_HZ), .REF_HZ(REF_HZ)) u_pre (
      .clk(clk), .rst_n(rst_n), .load(accept), .target(target_hz),
      .fin(pre_fin), .ft(ft), .expo(expo), .ratio(ratio), .rem(rem)
   );

   dclk_mstep #(.TW(TW), .NW(NW), .MW(MW), .RW(RW), .REF_HZ(REF_HZ)) u_step (
      .clk(clk), .rst_n(rst_n), .clear(pre_fin), .step(step),
      .ratio(ratio), .rem(rem), .n(n), .m(m)
   );

   dclk_score #(.TW(TW), .NW(NW), .MW(MW), .REF_HZ(REF_HZ), .M_MIN(M_MIN),
                .M_MAX(M_MAX), .LOOP_SH(LOOP_SH)) u_score (
      .clk(clk), .rst_n(rst_n), .clear(pre_fin), .eval(eval), .ft(ft), .n(n), .m(m),
      .best_ok(best_ok), .best_n(best_n), .best_m(best_m)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         done      <= 1'b0;
         range_err <= 1'b0;
         no_sol    <= 1'b0;
         m_code    <= '0;
         n_code    <= '0;
         div_code  <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  m_code    <= '0;
                  n_code    <= '0;
                  div_code  <= '0;
                  no_sol    <= 1'b0;
                  range_err <= reject;
                  done      <= reject;
                  if (!reject) st <= ST_PREP;
               end
            end
            ST_PREP:  if (pre_fin) st <= ST_SWEEP;
            ST_SWEEP: if (last) st <= ST_FIN;
            default: begin
               st   <= ST_IDLE;
               done <= 1'b1;
               if (best_ok) begin
                  m_code   <= 8'(m_fin - MW'(2));
                  n_code   <= 8'(best_n - NW'(2));
                  div_code <= {expo, 1'b0, !wide_m, 2'b00};
               end else begin
                  no_sol <= 1'b1;
               end
            end
         endcase
      end
   end

   a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r2_error_clears_codes: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |-> (m_code == 8'd0 && n_code == 8'd0 && div_code == 8'd0 && !no_sol));

   a_r7_divisor_spare_bits: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (div_code[3] == 1'b0 && div_code[1:0] == 2'b00));

   a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(m_code) && $stable(n_code) && $stable(div_code)));

endmodule

// File: tb/sim_dclk_pll_search.sv
`timescale 1ns/1ps
module sim_dclk_pll_search;

   localparam longint REFB   = 14318180;
   localparam longint FLOORB = 100000000;
   localparam longint LOB    = 3125000;
   localparam longint HIB    = 220000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] target_hz = '0;
   logic        busy, done, range_err, no_sol;
   logic [7:0]  m_code, n_code, div_code;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dclk_pll_search u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
      .busy(busy), .done(done), .range_err(range_err), .no_sol(no_sol),
      .m_code(m_code), .n_code(n_code), .div_code(div_code)
   );

   // behavioural model state
   bit       e_busy = 0, e_done = 0, e_rerr = 0, e_nosol = 0;
   int       e_cnt = 0;
   bit [7:0] e_m = 0, e_n = 0, e_d = 0;
   bit [7:0] p_m = 0, p_n = 0, p_d = 0;
   bit       p_ns = 0;

   function automatic void ref_calc(input longint t, output bit [7:0] mc, output bit [7:0] nc,
                                    output bit [7:0] dc, output bit ns, output int lat);
      longint ft = t;
      int     k = 0;
      longint q, r, be, bn, bm;
      bit     found = 0;
      while (ft < FLOORB) begin
         ft = ft * 2;
         k++;
      end
      q = ft / REFB;
      r = ft % REFB;
      be = 0; bn = 0; bm = 0;
      for (int nn = 3; nn <= 257; nn++) begin
         longint mm = nn * q + (nn * r) / REFB;
         if (mm >= 3 && mm <= 1028) begin
            longint ms = (mm > 257) ? (mm & ~longint'(3)) : mm;
            longint e = ft * nn - REFB * ms;
            if (e < 0) e = -e;
            if (!found || e < be) begin
               found = 1; be = e; bn = nn; bm = mm;
            end
         end
      end
      lat = k + int'(q) + 261;
      if (!found) begin
         ns = 1; mc = 0; nc = 0; dc = 0;
      end else begin
         ns = 0;
         nc = 8'(bn - 2);
         if (bm > 257) begin
            mc = 8'((bm >> 2) - 2);
            dc = 8'(k << 4);
         end else begin
            mc = 8'(bm - 2);
            dc = 8'((k << 4) | 4);
         end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         e_busy = 0; e_done = 0; e_rerr = 0; e_nosol = 0; e_cnt = 0;
         e_m = 0; e_n = 0; e_d = 0;
      end else begin
         e_done = 0;
         if (e_busy) begin
            e_cnt--;
            if (e_cnt == 0) begin
               e_busy = 0; e_done = 1;
               e_m = p_m; e_n = p_n; e_d = p_d; e_nosol = p_ns;
            end
         end else if (start) begin
            e_m = 0; e_n = 0; e_d = 0; e_nosol = 0;
            if (longint'(target_hz) > HIB || longint'(target_hz) < LOB) begin
               e_rerr = 1; e_done = 1;
            end else begin
               int lat;
               e_rerr = 0; e_busy = 1;
               ref_calc(longint'(target_hz), p_m, p_n, p_d, p_ns, lat);
               e_cnt = lat;
            end
         end
      end
   end

   task automatic chk(input string rq, input string nm, input longint act, input longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s at %0t: actual %0d expected %0d", rq, nm, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!finished) begin
         chk("R8 R9", "busy", busy, e_busy);
         chk("R8", "done", done, e_done);
         chk("R2 R3", "range_err", range_err, e_rerr);
         chk("R11", "no_sol", no_sol, e_nosol);
         chk("R5 R6 R7 R10", "m_code", m_code, e_m);
         chk("R5", "n_code", n_code, e_n);
         chk("R4 R7", "div_code", div_code, e_d);
      end
   end

   task automatic kick(input longint t);
      @(negedge clk);
      start = 1'b1;
      target_hz = 32'(t);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run(input longint t);
      kick(t);
      while (e_busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      // R1: outputs during and right after reset are compared against zero
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run(25175000);    // R4: two doublings
      run(220000001);   // R2: above window
      run(3124999);     // R2: below window
      run(3125000);     // R3: lower limit, five doublings
      run(220000000);   // R3: upper limit, no doubling
      run(100227260);   // R5: exact multiple, tie resolved to smallest N
      run(99999999);    // R4: one doubling
      run(100000000);   // R4: on the floor
      run(65000000);    // R6: extended M candidates in play
      run(135000000);
      run(40000000);
      // R9: second start during a search is ignored
      kick(108000000);
      repeat (40) @(negedge clk);
      kick(50000000);
      while (e_busy) @(negedge clk);
      // R10: back-to-back start right after done clears then refills
      kick(74250000);
      while (e_busy) @(negedge clk);
      kick(31500000);
      while (e_busy) @(negedge clk);
      repeat (6) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      #4000000;
      if (!finished) begin
         finished = 1'b1;
         mismatched++;
         compared++;
         $display("FAIL watchdog expired: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule